// File: doc/BRIEF.md
# Pipelined Unsigned-to-Float Conversion Unit

This block executes one instruction: turn an unsigned 32-bit integer held in a floating-point register into its IEEE-754 single-precision value. It holds an eight-entry, 32-bit register file. When a valid instruction word matches the conversion encoding, the block reads the source register in the issue cycle. It finds the leading one in that same cycle. In the following cycle it normalises and rounds the value to nearest-even, and writes the result back at the end of that cycle. The result can therefore be seen two cycles after issue, once one delay-slot instruction has gone by.

A load port fills registers from outside. A separate load port sets a 7-bit status flag register, and the conversion never changes those flags. The delay-slot instruction must not name the pending destination. The block drives a hazard output in that cycle when the instruction does name it. Instruction words that do not match the encoding have no effect on the registers or the flags.

Top module: `u2f_conv_unit`

## Requirements
- R1: A word is a conversion request only when instr_valid is high, bits 15:0 equal 0xE68B and bits 31:22 are all zero. Bits 21:19 select the source register and bits 18:16 select the destination register.
- R2: The destination register keeps its old value after the clock edge that ends the issue cycle. It holds the result after the next edge, so the result is visible two cycles after issue.
- R3: The result sign bit is 0. The biased exponent is 127 plus the index of the leading one. Any input below 2^24 converts exactly (1 → 0x3F800000, 5 → 0x40A00000, 0x00FFFFFF → 0x4B7FFFFF).
- R4: An input with more than 24 significant bits is rounded to nearest, with ties going to even, and a carry out of the rounding increments the exponent. Examples: 0x80001111 → 0x4F000011, 0xFFFFFFFF → 0x4F800000, 0x01000001 → 0x4B800000, 0x01000003 → 0x4B800002.
- R5: A zero input gives 0x00000000.
- R6: hazard is high in a cycle only when all three of these hold: a conversion issued in the previous cycle, instr_valid is high, and the current word's bits 21:19 or bits 18:16 equal that conversion's destination. The encoding of the current word does not matter.
- R7: The flag register changes only through flag_ld_en and never through a conversion.
- R8: A word that fails the match, or a matching word with instr_valid low, changes no register and no flag.
- R9: The source operand is read in the issue cycle. A conversion in the delay slot that reads the pending destination therefore gets that register's previous value.
- R10: If a write-back and a load target the same register on the same edge, the write-back value is stored.
- R11: Synchronous reset clears all registers and the flags and removes any pending result. hazard is low afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr_word | input | 32 | Instruction word |
| ld_en | input | 1 | Load a register from ld_data |
| ld_idx | input | 3 | Register index for the load |
| ld_data | input | 32 | Load value |
| flag_ld_en | input | 1 | Load the flag register |
| flag_ld_data | input | 7 | Flag load value |
| rf_flat | output | 256 | All registers; register i is at bits [32*i+31:32*i] |
| flags | output | 7 | Status flag register |
| hazard | output | 1 | Delay-slot instruction names the pending destination |

## Verification
A wrong pipeline register shows up at the register-file output exactly two cycles after issue, either as a value written one cycle early or late, or as a value written to the wrong index. A fault in the leading-one position or the rounding state shows up in that same cycle as an exponent or mantissa that differs from the integer-based reference. The flags and the hazard line are compared in every cycle, so any stray flag update shows up on the edge that causes it. A hazard decision made against stale pending state shows up in the delay-slot cycle itself.

// File: rtl/u2f_pkg.sv
package u2f_pkg;
    parameter int unsigned DW     = 32;
    parameter int unsigned NREG   = 8;
    parameter int unsigned NFLAG  = 7;
    parameter int unsigned EXPW   = 8;
    parameter int unsigned MANW   = 23;
    parameter int unsigned BIAS   = 127;
    localparam int unsigned IDXW  = $clog2(NREG);
    localparam int unsigned POSW  = $clog2(DW);
    localparam int unsigned DST_LSB = 16;
    localparam int unsigned SRC_LSB = DST_LSB + IDXW;
    localparam int unsigned ZHI_LSB = SRC_LSB + IDXW;
    localparam logic [15:0] OPC_LO = 16'hE68B;

    typedef logic [DW-1:0]   word_t;
    typedef logic [IDXW-1:0] ridx_t;
    typedef logic [POSW-1:0] pos_t;

    typedef struct packed {
        logic  hit;
        ridx_t src;
        ridx_t dst;
    } dec_t;

    typedef struct packed {
        logic  vld;
        ridx_t dst;
        word_t opnd;
        logic  nz;
        pos_t  pos;
    } stage_t;

    function automatic logic opc_match(word_t w);
        return (w[15:0] == OPC_LO) && (w[DW-1:ZHI_LSB] == '0);
    endfunction

    function automatic ridx_t fld_src(word_t w);
        return w[SRC_LSB +: IDXW];
    endfunction

    function automatic ridx_t fld_dst(word_t w);
        return w[DST_LSB +: IDXW];
    endfunction
endpackage

// File: rtl/u2f_decode.sv
module u2f_decode
    import u2f_pkg::*;
(
    input  word_t word,
    output dec_t  dec
);
    always_comb begin
        dec.hit = opc_match(word);
        dec.src = fld_src(word);
        dec.dst = fld_dst(word);
    end
endmodule

// File: rtl/u2f_lead_one.sv
module u2f_lead_one #(
    parameter int unsigned W  = 32,
    localparam int unsigned PW = $clog2(W)
) (
    input  logic [W-1:0]  x,
    output logic [PW-1:0] pos,
    output logic          nz
);
    always_comb begin
        pos = '0;
        for (int i = 0; i < W; i++) begin
            if (x[i]) pos = PW'(i);
        end
        nz = |x;
    end
endmodule

// File: rtl/u2f_round_pack.sv
module u2f_round_pack
    import u2f_pkg::*;
(
    input  word_t opnd,
    input  pos_t  pos,
    input  logic  nz,
    output word_t result
);
    localparam int unsigned GPOS = DW - 2 - MANW;

    pos_t              shamt;
    word_t             norm;
    logic [MANW-1:0]   man;
    logic              guard;
    logic              sticky;
    logic              rnd_up;
    logic [EXPW-1:0]   expo;
    word_t             packed_v;

    always_comb begin
        shamt    = POSW'(DW - 1) - pos;
        norm     = opnd << shamt;
        man      = norm[DW-2 -: MANW];
        guard    = norm[GPOS];
        sticky   = |norm[GPOS-1:0];
        rnd_up   = guard & (sticky | man[0]);
        expo     = EXPW'(BIAS) + EXPW'(pos);
        packed_v = {1'b0, expo, man};
        result   = nz ? (packed_v + DW'(rnd_up)) : '0;
    end
endmodule

// File: rtl/u2f_regfile.sv
module u2f_regfile
    import u2f_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  ridx_t            rd_idx,
    output word_t            rd_data,
    input  logic             pri_en,
    input  ridx_t            pri_idx,
    input  word_t            pri_data,
    input  logic             sec_en,
    input  ridx_t            sec_idx,
    input  word_t            sec_data,
    output logic [NREG*DW-1:0] flat
);
    word_t mem [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[i] <= '0;
            end else if (pri_en && pri_idx == ridx_t'(i)) begin
                mem[i] <= pri_data;
            end else if (sec_en && sec_idx == ridx_t'(i)) begin
                mem[i] <= sec_data;
            end
        end
        assign flat[i*DW +: DW] = mem[i];
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/u2f_conv_unit.sv
module u2f_conv_unit
    import u2f_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  instr_valid,
    input  logic [31:0]           instr_word,
    input  logic                  ld_en,
    input  logic [2:0]            ld_idx,
    input  logic [31:0]           ld_data,
    input  logic                  flag_ld_en,
    input  logic [6:0]            flag_ld_data,
    output logic [255:0]          rf_flat,
    output logic [6:0]            flags,
    output logic                  hazard
);
    dec_t   dec;
    word_t  src_val;
    pos_t   lo_pos;
    logic   lo_nz;
    stage_t s1;
    word_t  wb_data;
    logic   wb_en;
    logic [NFLAG-1:0] flag_q;

    u2f_decode u_dec (
        .word (instr_word),
        .dec  (dec)
    );

    u2f_regfile u_rf (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (dec.src),
        .rd_data  (src_val),
        .pri_en   (wb_en),
        .pri_idx  (s1.dst),
        .pri_data (wb_data),
        .sec_en   (ld_en),
        .sec_idx  (ld_idx),
        .sec_data (ld_data),
        .flat     (rf_flat)
    );

    u2f_lead_one #(.W(DW)) u_lo (
        .x   (src_val),
        .pos (lo_pos),
        .nz  (lo_nz)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.vld  <= instr_valid & dec.hit;
            s1.dst  <= dec.dst;
            s1.opnd <= src_val;
            s1.nz   <= lo_nz;
            s1.pos  <= lo_pos;
        end
    end

    u2f_round_pack u_rp (
        .opnd   (s1.opnd),
        .pos    (s1.pos),
        .nz     (s1.nz),
        .result (wb_data)
    );

    assign wb_en = s1.vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
        end else if (flag_ld_en) begin
            flag_q <= flag_ld_data;
        end
    end

    assign flags  = flag_q;
    assign hazard = s1.vld & instr_valid & ((dec.src == s1.dst) | (dec.dst == s1.dst));
endmodule

// File: rtl/u2f_conv_sva.sv
module u2f_conv_sva
    import u2f_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        instr_valid,
    input logic [31:0] instr_word,
    input logic        flag_ld_en,
    input logic [6:0]  flags,
    input logic        hazard,
    input logic [31:0] s1_opnd,
    input logic        wb_en,
    input logic [31:0] wb_data
);
    // R2: a matching issue leads to a write-back in the next cycle
    a_r2_wb_next: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && opc_match(instr_word)) |=> wb_en);

    // R8: no write-back without a matching valid issue one cycle earlier
    a_r8_no_spurious_wb: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> $past(instr_valid && opc_match(instr_word)));

    // R3: result sign is clear
    a_r3_sign_clear: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> !wb_data[31]);

    // R5: zero operand gives positive zero
    a_r5_zero: assert property (@(posedge clk) disable iff (rst)
        (wb_en && s1_opnd == '0) |-> (wb_data == '0));

    // R6: hazard needs a valid instruction now and an issue one cycle earlier
    a_r6_hazard_cause: assert property (@(posedge clk) disable iff (rst)
        hazard |-> (instr_valid && $past(instr_valid && opc_match(instr_word))));

    // R7: flags move only on a flag load
    a_r7_flags_hold: assert property (@(posedge clk) disable iff (rst)
        !flag_ld_en |=> $stable(flags));
endmodule

bind u2f_conv_unit u2f_conv_sva u_chk (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .instr_word  (instr_word),
    .flag_ld_en  (flag_ld_en),
    .flags       (flags),
    .hazard      (hazard),
    .s1_opnd     (s1.opnd),
    .wb_en       (wb_en),
    .wb_data     (wb_data)
);

// File: tb/u2f_conv_unit_test.sv
module u2f_conv_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic         clk = 1'b0;
    logic         rst;
    logic         instr_valid;
    logic [31:0]  instr_word;
    logic         ld_en;
    logic [2:0]   ld_idx;
    logic [31:0]  ld_data;
    logic         flag_ld_en;
    logic [6:0]   flag_ld_data;
    logic [255:0] rf_flat;
    logic [6:0]   flags;
    logic         hazard;

    int    checks   = 0;
    int    failures = 0;
    int    cyc      = 0;
    string cur_req  = "R11";

    logic [31:0] m_rf [8];
    logic [6:0]  m_flags;
    logic        m_pv;
    logic [2:0]  m_pd;
    logic [31:0] m_pval;

    always #(CLK_PERIOD/2) clk = ~clk;

    u2f_conv_unit uut (
        .clk          (clk),
        .rst          (rst),
        .instr_valid  (instr_valid),
        .instr_word   (instr_word),
        .ld_en        (ld_en),
        .ld_idx       (ld_idx),
        .ld_data      (ld_data),
        .flag_ld_en   (flag_ld_en),
        .flag_ld_data (flag_ld_data),
        .rf_flat      (rf_flat),
        .flags        (flags),
        .hazard       (hazard)
    );

    function automatic logic [31:0] ref_conv(logic [31:0] x);
        longint v, q, r, half;
        int e, sh;
        if (x == 0) return 32'h0;
        v = longint'(x);
        e = 31;
        while (x[e] == 1'b0) e--;
        if (e <= 23) begin
            q = v << (23 - e);
        end else begin
            sh   = e - 23;
            q    = v >> sh;
            r    = v & ((64'sd1 << sh) - 1);
            half = 64'sd1 << (sh - 1);
            if (r > half || (r == half && q[0])) q++;
            if (q == (64'sd1 << 24)) begin
                q = 64'sd1 << 23;
                e++;
            end
        end
        return {1'b0, 8'(e + 127), q[22:0]};
    endfunction

    function automatic logic [31:0] mk(int src, int dst);
        return {10'b0, 3'(src), 3'(dst), 16'hE68B};
    endfunction

    function automatic logic [31:0] rf_get(int i);
        return rf_flat[i*32 +: 32];
    endfunction

    // reference model, updated on every rising edge
    always @(posedge clk) begin
        logic        nv;
        logic [2:0]  nd;
        logic [31:0] nval;
        if (rst) begin
            for (int i = 0; i < 8; i++) m_rf[i] = 32'h0;
            m_flags = '0;
            m_pv = 1'b0; m_pd = '0; m_pval = '0;
        end else begin
            nv   = instr_valid && instr_word[15:0] == 16'hE68B && instr_word[31:22] == 10'h0;
            nd   = instr_word[18:16];
            nval = ref_conv(m_rf[instr_word[21:19]]);
            if (ld_en) m_rf[ld_idx] = ld_data;
            if (m_pv) m_rf[m_pd] = m_pval;
            if (flag_ld_en) m_flags = flag_ld_data;
            m_pv = nv; m_pd = nd; m_pval = nval;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            failures++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(logic ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic check_reg(int i, logic [31:0] exp, string req);
        chk(rf_get(i) === exp, req, rf_get(i), exp);
    endtask

    function automatic logic exp_hazard();
        return m_pv && instr_valid &&
               (instr_word[21:19] == m_pd || instr_word[18:16] == m_pd);
    endfunction

    // one cycle: inputs already driven; check hazard, then state after the edge
    task automatic step();
        #1;
        chk(hazard === exp_hazard(), cur_req, {31'b0, hazard}, {31'b0, exp_hazard()});
        @(negedge clk);
        for (int i = 0; i < 8; i++) chk(rf_get(i) === m_rf[i], cur_req, rf_get(i), m_rf[i]);
        chk(flags === m_flags, cur_req, {25'b0, flags}, {25'b0, m_flags});
        instr_valid = 1'b0;
        ld_en       = 1'b0;
        flag_ld_en  = 1'b0;
    endtask

    task automatic load(int idx, logic [31:0] val);
        ld_en = 1'b1; ld_idx = 3'(idx); ld_data = val;
        step();
    endtask

    task automatic conv(int src, int dst);
        instr_valid = 1'b1; instr_word = mk(src, dst);
        step();
    endtask

    task automatic run_val(logic [31:0] val, logic [31:0] exp, string req);
        cur_req = req;
        load(0, val);
        conv(0, 1);
        step();
        check_reg(1, exp, req);
    endtask

    initial begin
        logic [31:0] lf;
        logic [31:0] snap [8];
        logic [31:0] old5;
        logic [31:0] a;
        rst = 1'b1; instr_valid = 1'b0; instr_word = '0;
        ld_en = 1'b0; ld_idx = '0; ld_data = '0;
        flag_ld_en = 1'b0; flag_ld_data = '0;
        repeat (3) @(negedge clk);
        // R11: reset state
        for (int i = 0; i < 8; i++) check_reg(i, 32'h0, "R11");
        chk(flags === 7'h0, "R11", {25'b0, flags}, 32'h0);
        chk(hazard === 1'b0, "R11", {31'b0, hazard}, 32'h0);
        rst = 1'b0;

        // R7: flags preset, must survive all conversions
        cur_req = "R7";
        flag_ld_en = 1'b1; flag_ld_data = 7'h2A;
        step();

        // R2 / R4: timing and the stated example
        cur_req = "R2";
        load(3, 32'h80001111);
        conv(3, 4);
        check_reg(4, 32'h0, "R2");
        step();
        check_reg(4, 32'h4F000011, "R4");

        // R1: field positions
        cur_req = "R1";
        load(6, 32'd100);
        conv(6, 2);
        step();
        check_reg(2, 32'h42C80000, "R1");

        run_val(32'hFFFFFFFF, 32'h4F800000, "R4");
        run_val(32'h0,        32'h0,        "R5");
        run_val(32'h1,        32'h3F800000, "R3");
        run_val(32'h5,        32'h40A00000, "R3");
        run_val(32'h00FFFFFF, 32'h4B7FFFFF, "R3");
        run_val(32'h01000001, 32'h4B800000, "R4");
        run_val(32'h01000003, 32'h4B800002, "R4");

        // R4: pseudo-random operands against the integer reference
        lf = 32'h1234_5678;
        for (int k = 0; k < 150; k++) begin
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            run_val(lf >> (k % 32), ref_conv(lf >> (k % 32)), "R4");
        end

        // R6 / R9: delay slot reads pending destination
        cur_req = "R6";
        load(2, 32'd7);
        old5 = rf_get(5);
        conv(2, 5);
        instr_valid = 1'b1; instr_word = mk(5, 6);
        #1 chk(hazard === 1'b1, "R6", {31'b0, hazard}, 32'h1);
        step();
        step();
        check_reg(5, 32'h40E00000, "R6");
        check_reg(6, ref_conv(old5), "R9");

        conv(0, 7);
        instr_valid = 1'b1; instr_word = mk(1, 7);
        #1 chk(hazard === 1'b1, "R6", {31'b0, hazard}, 32'h1);
        step();
        step();
        conv(0, 7);
        instr_valid = 1'b1; instr_word = mk(1, 2);
        #1 chk(hazard === 1'b0, "R6", {31'b0, hazard}, 32'h0);
        step();
        step();
        conv(0, 7);
        instr_valid = 1'b1; instr_word = {10'h0, 3'd7, 3'd1, 16'h1234};
        #1 chk(hazard === 1'b1, "R6", {31'b0, hazard}, 32'h1);
        step();
        instr_valid = 1'b1; instr_word = mk(7, 7);
        #1 chk(hazard === 1'b0, "R6", {31'b0, hazard}, 32'h0);
        step();
        step();

        // R8: non-matching words and invalid strobes have no effect
        cur_req = "R8";
        load(0, 32'h0000_0ABC);
        step();
        for (int i = 0; i < 8; i++) snap[i] = rf_get(i);
        instr_valid = 1'b1; instr_word = mk(0, 1) ^ 32'h1;
        step();
        instr_valid = 1'b1; instr_word = mk(0, 1) | 32'h0040_0000;
        step();
        instr_valid = 1'b0; instr_word = mk(0, 1);
        step();
        step();
        step();
        for (int i = 0; i < 8; i++) check_reg(i, snap[i], "R8");

        // R10: write-back beats a load to the same register
        cur_req = "R10";
        a = 32'h0123_4567;
        load(0, a);
        conv(0, 3);
        ld_en = 1'b1; ld_idx = 3'd3; ld_data = 32'hDEAD_BEEF;
        step();
        step();
        check_reg(3, ref_conv(a), "R10");

        chk(flags === 7'h2A, "R7", {25'b0, flags}, 32'h2A);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule